// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block divides one 32-bit operand by another for a small processor core. The caller presents a dividend, a divisor and a signedness select, and pulses a start strobe. Unsigned mode returns the floor quotient. Signed mode treats both operands as two's complement and truncates the quotient toward zero. A non-zero divisor takes one restoring shift-subtract step per quotient bit, followed by one sign fix-up cycle. The quotient then appears together with a one-cycle done pulse and a write-back qualifier.

A zero divisor is detected in the start cycle and finishes in a single cycle with a quotient of zero. It also sets a sticky divide-by-zero status bit, which only reset or an explicit clear strobe removes. If both the global exception enable and the divide-by-zero trap configuration bit are set when the operation is accepted, the block raises an exception request. It also loads its cause register with the divide-by-zero code and withholds write-back of the result.

Top module: `int_div_trap`

## Requirements
- R1: With signed_i low, a start accepted with a non-zero divisor yields the unsigned floor quotient. done_o and wb_o are high for one cycle beginning 33 rising edges after the accepting edge (32 iteration steps plus one fix-up step). busy_o is high from the accepting edge until that same edge.
- R2: With signed_i high, both operands are two's complement and the quotient is truncated toward zero; the quotient is negative exactly when the operand signs differ.
- R3: Signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000 with the normal latency. It raises no exception and does not touch the sticky bit.
- R4: A start with divisor 0 completes on the next rising edge. done_o is high for one cycle and quotient_o is 0.
- R5: A zero-divisor start sets dz_sticky_o whatever the enables are. It stays set until a cycle with dz_clear_i high, and a zero-divisor start in that same cycle takes precedence over the clear.
- R6: exc_req_o pulses together with done_o only for a zero-divisor start sampled with both exc_enable_i and dz_trap_cfg_i high. On that edge exc_cause_o is loaded with 5'h05. Otherwise exc_cause_o keeps its value.
- R7: wb_o accompanies every done_o pulse except one whose exc_req_o is high.
- R8: A start strobe while busy_o is high is ignored. The running operation finishes with its own result and timing.
- R9: After reset every output is 0. quotient_o holds the last result until the next done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted when not busy |
| signed_i | input | 1 | 1 selects two's-complement division |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| exc_enable_i | input | 1 | Global exception enable |
| dz_trap_cfg_i | input | 1 | Divide-by-zero trap configuration enable |
| dz_clear_i | input | 1 | Clears the sticky divide-by-zero bit |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Quotient, held until the next completion |
| wb_o | output | 1 | Result may be written back |
| dz_sticky_o | output | 1 | Sticky divide-by-zero status |
| exc_req_o | output | 1 | Exception request pulse |
| exc_cause_o | output | 5 | Exception cause register |

## Verification
The bench targets the sign corners: mixed-sign and both-negative operands, the most negative value divided by -1, and an all-ones unsigned dividend. A design that negated on the wrong condition, or that flagged overflow, would return a wrong sign or a spurious trap. All four combinations of the two enables are applied to zero divisors. A design that traps on either enable alone, or that still writes back a trapped result, shows up in exc_req_o and wb_o. The bench also clears the sticky bit in the same cycle as a new zero divisor, and strobes start mid-iteration. A design that lost the set against the clear, or that restarted, would show the wrong status or the wrong completion cycle.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_DIVZERO = 5'h05;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_FIX
  } div_state_e;
endpackage

// File: rtl/div_iter.sv
module div_iter import div_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] num_mag_i,
  input  logic [WIDTH-1:0] den_mag_i,
  input  logic             neg_i,
  output logic             busy_o,
  output logic             fix_now_o,
  output logic [WIDTH-1:0] fix_val_o
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  div_state_e       st_q;
  logic [WIDTH-1:0] rem_q, quo_q, den_q;
  logic             neg_q;
  logic [CW-1:0]    cnt_q;

  logic [WIDTH:0]   shifted, diff;
  logic             step_ok;

  function automatic logic [WIDTH-1:0] apply_sign(input logic [WIDTH-1:0] mag,
                                                  input logic neg);
    return neg ? (~mag + 1'b1) : mag;
  endfunction

  assign shifted   = {rem_q, quo_q[WIDTH-1]};
  assign diff      = shifted - {1'b0, den_q};
  assign step_ok   = ~diff[WIDTH];
  assign busy_o    = (st_q != ST_IDLE);
  assign fix_now_o = (st_q == ST_FIX);
  assign fix_val_o = apply_sign(quo_q, neg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      neg_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (load_i) begin
          quo_q <= num_mag_i;
          rem_q <= '0;
          den_q <= den_mag_i;
          neg_q <= neg_i;
          cnt_q <= '0;
          st_q  <= ST_ITER;
        end
        ST_ITER: begin
          rem_q <= step_ok ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
          quo_q <= {quo_q[WIDTH-2:0], step_ok};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) st_q <= ST_FIX;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1: fix-up follows the final iteration step
  assert_fix_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ITER && cnt_q == LAST_STEP) |=> fix_now_o);
  // R8: a load is only presented while idle
  assert_load_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o);
  // R1: busy drops right after fix-up
  assert_idle_after_fix_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fix_now_o |=> !busy_o);
endmodule

// File: rtl/dz_status.sv
module dz_status import div_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_evt_i,
  input  logic               trap_en_i,
  input  logic               clear_i,
  output logic               sticky_o,
  output logic               exc_req_o,
  output logic [CAUSE_W-1:0] cause_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_o  <= 1'b0;
      exc_req_o <= 1'b0;
      cause_o   <= '0;
    end else begin
      if (zero_evt_i)   sticky_o <= 1'b1;
      else if (clear_i) sticky_o <= 1'b0;
      exc_req_o <= zero_evt_i & trap_en_i;
      if (zero_evt_i & trap_en_i) cause_o <= CAUSE_DIVZERO;
    end
  end

  // R5: sticky only rises from a zero-divisor event
  assert_sticky_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_o) |-> $past(zero_evt_i));
  // R5: sticky holds while no clear is strobed
  assert_sticky_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_o && !clear_i) |=> sticky_o);
  // R6: cause changes only when a trap is taken
  assert_cause_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req_o |-> $stable(cause_o));
endmodule

// File: rtl/int_div_trap.sv
module int_div_trap import div_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   dividend_i,
  input  logic [WIDTH-1:0]   divisor_i,
  input  logic               exc_enable_i,
  input  logic               dz_trap_cfg_i,
  input  logic               dz_clear_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [WIDTH-1:0]   quotient_o,
  output logic               wb_o,
  output logic               dz_sticky_o,
  output logic               exc_req_o,
  output logic [CAUSE_W-1:0] exc_cause_o
);
  logic             accept, zero_div, zero_evt, load_evt, neg_res;
  logic             fix_now;
  logic [WIDTH-1:0] fix_val, num_mag, den_mag;
  logic             done_q;
  logic [WIDTH-1:0] quot_q;

  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v,
                                                 input logic is_signed);
    return (is_signed && v[WIDTH-1]) ? (~v + 1'b1) : v;
  endfunction

  assign accept   = start_i & ~busy_o;
  assign zero_div = (divisor_i == '0);
  assign zero_evt = accept & zero_div;
  assign load_evt = accept & ~zero_div;
  assign neg_res  = signed_i & (dividend_i[WIDTH-1] ^ divisor_i[WIDTH-1]);
  assign num_mag  = magnitude(dividend_i, signed_i);
  assign den_mag  = magnitude(divisor_i, signed_i);

  div_iter #(.WIDTH(WIDTH)) u_iter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_evt),
    .num_mag_i (num_mag),
    .den_mag_i (den_mag),
    .neg_i     (neg_res),
    .busy_o    (busy_o),
    .fix_now_o (fix_now),
    .fix_val_o (fix_val)
  );

  dz_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .zero_evt_i (zero_evt),
    .trap_en_i  (exc_enable_i & dz_trap_cfg_i),
    .clear_i    (dz_clear_i),
    .sticky_o   (dz_sticky_o),
    .exc_req_o  (exc_req_o),
    .cause_o    (exc_cause_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      quot_q <= '0;
    end else begin
      done_q <= fix_now | zero_evt;
      if (fix_now)       quot_q <= fix_val;
      else if (zero_evt) quot_q <= '0;
    end
  end

  assign done_o     = done_q;
  assign quotient_o = quot_q;
  assign wb_o       = done_q & ~exc_req_o;

  // R4: zero divisor completes next cycle with a zero quotient
  assert_zero_quotient_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (done_o && quotient_o == '0));
  // R6: a trap needs both enables and a zero divisor at acceptance
  assert_trap_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> $past(start_i && exc_enable_i && dz_trap_cfg_i && divisor_i == '0));
  // R7: a trapped result is never written back
  assert_no_wb_on_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> (done_o && !wb_o));
  // R9: quotient changes only with a completion
  assert_quot_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(quotient_o));
endmodule

// File: tb/int_div_trap_bench.sv
module int_div_trap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, signed_i = 1'b0;
  logic [31:0] dividend_i = '0, divisor_i = '0;
  logic        exc_enable_i = 1'b0, dz_trap_cfg_i = 1'b0, dz_clear_i = 1'b0;
  logic        busy_o, done_o, wb_o, dz_sticky_o, exc_req_o;
  logic [31:0] quotient_o;
  logic [4:0]  exc_cause_o;

  int vectors = 0, miscompares = 0, cycles = 0;
  string tag = "R9";

  // reference state
  logic        m_busy = 0, m_done = 0, m_wb = 0, m_sticky = 0, m_exc = 0;
  logic [31:0] m_q = 0, m_pend = 0;
  logic [4:0]  m_cause = 0;
  int          m_cnt = 0;

  always #5 clk = ~clk;

  int_div_trap u_int_div_trap (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .exc_enable_i(exc_enable_i), .dz_trap_cfg_i(dz_trap_cfg_i),
    .dz_clear_i(dz_clear_i), .busy_o(busy_o), .done_o(done_o),
    .quotient_o(quotient_o), .wb_o(wb_o), .dz_sticky_o(dz_sticky_o),
    .exc_req_o(exc_req_o), .exc_cause_o(exc_cause_o)
  );

  function automatic logic [31:0] ref_div(input logic [31:0] a, input logic [31:0] b,
                                          input logic s);
    longint x, y, q;
    if (s) begin
      x = longint'($signed(a));
      y = longint'($signed(b));
    end else begin
      x = longint'({32'd0, a});
      y = longint'({32'd0, b});
    end
    q = x / y;
    return q[31:0];
  endfunction

  always @(posedge clk) begin
    logic zacc;
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_done = 0; m_wb = 0;
      m_q = 0; m_sticky = 0; m_exc = 0; m_cause = 0;
    end else begin
      zacc = 0; m_done = 0; m_wb = 0; m_exc = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_wb = 1; m_q = m_pend;
        end
      end else if (start_i) begin
        if (divisor_i == 0) begin
          zacc = 1; m_done = 1; m_q = 0; m_sticky = 1;
          if (exc_enable_i && dz_trap_cfg_i) begin
            m_exc = 1; m_cause = 5'h05;
          end else m_wb = 1;
        end else begin
          m_busy = 1; m_cnt = 33;
          m_pend = ref_div(dividend_i, divisor_i, signed_i);
        end
      end
      if (dz_clear_i && !zacc) m_sticky = 0;
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (busy_o !== m_busy || done_o !== m_done || quotient_o !== m_q ||
        wb_o !== m_wb || dz_sticky_o !== m_sticky || exc_req_o !== m_exc ||
        exc_cause_o !== m_cause) begin
      miscompares++;
      $display("FAIL %s: got busy=%b done=%b q=%h wb=%b sticky=%b exc=%b cause=%h, expected busy=%b done=%b q=%h wb=%b sticky=%b exc=%b cause=%h",
               tag, busy_o, done_o, quotient_o, wb_o, dz_sticky_o, exc_req_o, exc_cause_o,
               m_busy, m_done, m_q, m_wb, m_sticky, m_exc, m_cause);
    end
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog (all R): got %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s,
                     input logic en, input logic cfg, input string t);
    @(negedge clk);
    tag = t;
    dividend_i = a; divisor_i = b; signed_i = s;
    exc_enable_i = en; dz_trap_cfg_i = cfg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);   // R9 reset state compared each cycle
    rst_n = 1'b1;
    // R1 unsigned
    run(32'd100, 32'd7, 0, 0, 0, "R1");
    run(32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R1");
    run(32'd5, 32'd10, 0, 0, 0, "R1");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R1");
    run(32'hFFFF_FFF9, 32'd2, 0, 0, 0, "R1");
    // R2 signed truncation
    run(-32'sd7, 32'd2, 1, 0, 0, "R2");
    run(32'd7, -32'sd2, 1, 0, 0, "R2");
    run(-32'sd7, -32'sd2, 1, 0, 0, "R2");
    run(32'h8000_0000, 32'd1, 1, 0, 0, "R2");
    // R3 overflow corner, enables on
    run(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 1, "R3");
    // R4/R6/R7 zero divisor with each enable pair
    run(32'd9, 32'd0, 0, 0, 0, "R4");
    run(32'd9, 32'd0, 1, 1, 0, "R6");
    run(32'd9, 32'd0, 0, 0, 1, "R6");
    run(32'd9, 32'd0, 0, 1, 1, "R7");
    // R5 clear, then clear colliding with a new zero divisor
    @(negedge clk); tag = "R5"; dz_clear_i = 1'b1;
    @(negedge clk); dz_clear_i = 1'b0;
    @(negedge clk);
    divisor_i = 0; exc_enable_i = 0; start_i = 1'b1; dz_clear_i = 1'b1;
    @(negedge clk); start_i = 1'b0; dz_clear_i = 1'b0;
    repeat (2) @(negedge clk);
    // R8 start while busy ignored
    @(negedge clk); tag = "R8";
    dividend_i = 32'd1000; divisor_i = 32'd3; signed_i = 0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    dividend_i = 32'd50; divisor_i = 32'd0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    // R9 quotient held after more idle cycles
    tag = "R9";
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule